// File: doc/BRIEF.md
# RGB Range Conversion Pipeline

This block is one color conversion stage in a display pipe. Each 24-bit RGB pixel goes through the same steps. A signed pre-offset is added to each input channel. A 3x3 coefficient matrix then mixes the channels. A per-channel post-offset is added, or a fixed black-level lift of +16 codes when that mode is selected. The result is rounded and clamped back to 8 bits per channel.

The main use is compressing full-range RGB (0..255) into studio-swing RGB (16..235) in two steps. The matrix scales the signal down to 0..219, and the offset stage lifts it to start at 16. The other use is pass-through: an identity matrix with zero offsets, so pixels still route through the unit but come out unchanged.

Pixels stream in and out with valid/ready handshakes. Settings arrive on a simple write port into a shadow copy. A frame-start strobe moves the shadow copy into the active copy, so one frame is always converted with one setting.

Top module: `csc_pipe`

## Requirements
- R1: After reset, `out_valid` is low and the active settings are the identity, with diagonal coefficients of unity and all offsets zero and the lift mode off.
- R2: A 16-bit coefficient code is decoded as follows. 0x7800 means exactly 1.0. A code with bits [15:12] zero means bits [11:0]/4096. Any other code counts as 0.
- R3: Write addresses hold the following settings.
  - Addresses 0/2/4, for output rows R/G/B: the coefficient for the R input in bits [31:16] and for the G input in bits [15:0].
  - Addresses 1/3/5: the coefficient for the B input in bits [31:16].
  - Address 6: the 10-bit two's-complement pre-offsets in codes, R in [9:0], G in [19:10], B in [29:20].
  - Addresses 7/8/9: the 13-bit two's-complement post-offsets for rows R/G/B in [12:0].
  - Address 10: the lift-mode bit in [0].
- R4: Output row r is computed as follows.
  - T = 2·Σc coef[r][c]·(x[c]+pre[c]) + 255·post[r], where coefficients are in units of 2^-12 and T is in units of 2^-13 code.
  - The output is floor((T+4096)/8192) before clamping.
- R5: With the lift-mode bit set, the post-offset term is replaced by 16·8192, which is exactly +16 codes, for every row.
- R6: Each output channel is clamped to 0..255.
- R7: With identity settings, every output pixel equals its input pixel bit for bit.
- R8: With diagonal code 0x0DB8 and post-offsets 0x202, or with lift mode and zero post-offsets, input 0 maps to 16 and input 255 maps to 235.
- R9: Writes go only to the shadow copy. The active copy takes the shadow contents on a `frame_start` cycle. A write in that same cycle does not reach the active copy until the next `frame_start`.
- R10: With `out_ready` held high, a pixel accepted on a rising edge appears on `out_valid` and `out_pix` after the third rising edge, counting the accepting edge.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_pix` hold, and no pixel is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Setting write strobe |
| cfg_wr_addr | input | ADDR_W (4) | Setting address |
| cfg_wr_data | input | 32 | Setting write data |
| frame_start | input | 1 | Copies shadow settings to active |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_pix | input | 24 | Input pixel, R [23:16], G [15:8], B [7:0] |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_pix | output | 24 | Output pixel, same packing as in_pix |

## Verification
The bench sends all 256 codes on each channel, with the channels skewed against each other, under several settings.

- **Identity settings** show whether the matrix and rounding are exact.
- **Compressed settings with programmed post-offsets, and again with lift mode**, show whether the two lift paths agree at black and white.
- **A cross-mixing matrix with an invalid coefficient code, a negative pre-offset and overflowing sums** separates the decode rules from the clamp at both ends.
- **Random stalls on the output** test hold and ordering.
- **Writes without a frame strobe, and a write landing in the strobe's own cycle**, show whether the shadow and active copies stay apart.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int NCH        = 3;
  localparam int CH_W       = 8;
  localparam int PIX_W      = NCH * CH_W;
  localparam int RAW_W      = 16;
  localparam int REG_W      = 2 * RAW_W;
  localparam int CFRAC      = 12;
  localparam int COEF_W     = CFRAC + 1;
  localparam int PRE_W      = 10;
  localparam int POST_W     = 13;
  localparam int OFRAC      = 13;
  localparam int X_W        = PRE_W + 1;
  localparam int PROD_W     = X_W + COEF_W + 1;
  localparam int ACC_W      = PROD_W + 2;
  localparam int T_W        = ACC_W + 3;
  localparam int BLANK_LIFT = 16 << OFRAC;
  localparam int ROUND_HALF = 1 << (OFRAC - 1);
  localparam int CH_MAX     = (1 << CH_W) - 1;

  localparam logic [RAW_W-1:0] UNITY_CODE = 16'h7800;

  localparam int PRE_ADDR  = 2 * NCH;
  localparam int POST_BASE = PRE_ADDR + 1;
  localparam int MODE_ADDR = POST_BASE + NCH;

  typedef struct packed {
    logic [NCH-1:0][NCH-1:0][RAW_W-1:0] coef;
    logic [NCH-1:0][PRE_W-1:0]          pre;
    logic [NCH-1:0][POST_W-1:0]         post;
    logic                               lift;
  } csc_cfg_t;

  function automatic csc_cfg_t cfg_identity();
    csc_cfg_t c;
    c = '0;
    for (int i = 0; i < NCH; i++) c.coef[i][i] = UNITY_CODE;
    return c;
  endfunction

  function automatic logic [COEF_W-1:0] coef_decode(logic [RAW_W-1:0] raw);
    if (raw == UNITY_CODE)
      return COEF_W'(1 << CFRAC);
    else if (raw[RAW_W-1:CFRAC] == '0)
      return COEF_W'(raw[CFRAC-1:0]);
    else
      return '0;
  endfunction
endpackage

// File: rtl/csc_cfg_regs.sv
module csc_cfg_regs
  import csc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              frame_start,
  output csc_cfg_t          active
);
  csc_cfg_t shadow;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= cfg_identity();
      active <= cfg_identity();
    end else begin
      if (frame_start) active <= shadow;
      if (wr_en) begin
        for (int r = 0; r < NCH; r++) begin
          if (wr_addr == ADDR_W'(2 * r)) begin
            shadow.coef[r][0] <= wr_data[REG_W-1:RAW_W];
            shadow.coef[r][1] <= wr_data[RAW_W-1:0];
          end
          if (wr_addr == ADDR_W'(2 * r + 1))
            shadow.coef[r][2] <= wr_data[REG_W-1:RAW_W];
          if (wr_addr == ADDR_W'(PRE_ADDR))
            shadow.pre[r] <= wr_data[r*PRE_W +: PRE_W];
          if (wr_addr == ADDR_W'(POST_BASE + r))
            shadow.post[r] <= wr_data[POST_W-1:0];
        end
        if (wr_addr == ADDR_W'(MODE_ADDR)) shadow.lift <= wr_data[0];
      end
    end
  end

  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(active))
    else $error("active settings changed without frame strobe"); // R9
endmodule

// File: rtl/csc_preoff.sv
module csc_preoff
  import csc_pkg::*;
(
  input  logic                      clk,
  input  logic                      adv,
  input  logic [PIX_W-1:0]          pix,
  input  logic [NCH-1:0][PRE_W-1:0] pre,
  output logic [NCH-1:0][X_W-1:0]   x1
);
  always_ff @(posedge clk) begin
    if (adv) begin
      for (int c = 0; c < NCH; c++)
        x1[c] <= {{(X_W-CH_W){1'b0}}, pix[(NCH-1-c)*CH_W +: CH_W]}
               + {{(X_W-PRE_W){pre[c][PRE_W-1]}}, pre[c]};
    end
  end
endmodule

// File: rtl/csc_row.sv
module csc_row
  import csc_pkg::*;
(
  input  logic                       clk,
  input  logic                       adv,
  input  logic [NCH-1:0][X_W-1:0]    x1,
  input  logic [NCH-1:0][COEF_W-1:0] coef,
  input  logic [POST_W-1:0]          post,
  input  logic                       lift,
  output logic [CH_W-1:0]            y
);
  logic signed [PROD_W-1:0] prod [NCH];
  logic [ACC_W-1:0] acc_d, acc;
  logic [T_W-1:0]   post_ext, lift_t, tsum, q;
  logic [CH_W-1:0]  y_d;

  always_comb begin
    acc_d = '0;
    for (int c = 0; c < NCH; c++) begin
      prod[c] = PROD_W'($signed(x1[c])) * PROD_W'($signed({1'b0, coef[c]}));
      acc_d   = acc_d + {{(ACC_W-PROD_W){prod[c][PROD_W-1]}}, prod[c]};
    end
  end

  always_comb begin
    post_ext = {{(T_W-POST_W){post[POST_W-1]}}, post};
    lift_t   = lift ? T_W'(BLANK_LIFT) : (post_ext << CH_W) - post_ext;
    tsum     = ({{(T_W-ACC_W){acc[ACC_W-1]}}, acc} << (OFRAC - CFRAC))
             + lift_t + T_W'(ROUND_HALF);
    q        = T_W'($signed(tsum) >>> OFRAC);
    if (q[T_W-1])                y_d = '0;
    else if (q > T_W'(CH_MAX))   y_d = '1;
    else                         y_d = q[CH_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      acc <= acc_d;
      y   <= y_d;
    end
  end
endmodule

// File: rtl/csc_pipe.sv
module csc_pipe
  import csc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [ADDR_W-1:0] cfg_wr_addr,
  input  logic [REG_W-1:0]  cfg_wr_data,
  input  logic              frame_start,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PIX_W-1:0]  in_pix,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_pix
);
  csc_cfg_t active;
  logic [NCH-1:0][NCH-1:0][COEF_W-1:0] cdec;
  logic [NCH-1:0][X_W-1:0] x1;
  logic [NCH-1:0][CH_W-1:0] y_row;
  logic v1, v2, v3, adv;

  assign adv       = out_ready || !v3;
  assign in_ready  = adv;
  assign out_valid = v3;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
    end else if (adv) begin
      v1 <= in_valid; v2 <= v1; v3 <= v2;
    end
  end

  csc_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr),
    .wr_data(cfg_wr_data), .frame_start(frame_start), .active(active)
  );

  always_comb begin
    for (int r = 0; r < NCH; r++)
      for (int c = 0; c < NCH; c++)
        cdec[r][c] = coef_decode(active.coef[r][c]);
  end

  csc_preoff u_pre (
    .clk(clk), .adv(adv), .pix(in_pix), .pre(active.pre), .x1(x1)
  );

  for (genvar r = 0; r < NCH; r++) begin : g_row
    csc_row u_row (
      .clk(clk), .adv(adv), .x1(x1), .coef(cdec[r]),
      .post(active.post[r]), .lift(active.lift), .y(y_row[r])
    );
    assign out_pix[(NCH-1-r)*CH_W +: CH_W] = y_row[r];
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid)
    else $error("output valid dropped under stall"); // R11
  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> $stable(out_pix))
    else $error("output pixel changed under stall"); // R11
  AST_LATENCY3: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && in_ready, 3) && $past(!rst, 3) && $past(!rst, 2) &&
    $past(!rst, 1) && $past(out_ready, 2) && $past(out_ready, 1) |-> out_valid)
    else $error("pixel not delivered after three edges"); // R10
  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> !out_valid)
    else $error("output valid right after reset"); // R1
endmodule

// File: tb/tb_csc_pipe.sv
module tb_csc_pipe;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr_en = 1'b0;
  logic [3:0] cfg_wr_addr = '0;
  logic [31:0] cfg_wr_data = '0;
  logic frame_start = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [23:0] in_pix = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [23:0] out_pix;

  always #5 clk = ~clk;

  csc_pipe dut (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
    .cfg_wr_data(cfg_wr_data), .frame_start(frame_start), .in_valid(in_valid),
    .in_ready(in_ready), .in_pix(in_pix), .out_valid(out_valid),
    .out_ready(out_ready), .out_pix(out_pix)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [23:0] exp_q[$];
  logic [23:0] last_out = '0;
  bit stall_mode = 1'b0;
  string cur_req = "R1 R7 identity";
  int s_coef[3][3], a_coef[3][3];
  int s_pre[3], a_pre[3], s_post[3], a_post[3];
  bit s_lift = 1'b0, a_lift = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int dec(input logic [15:0] raw);
    if (raw == 16'h7800) return 4096;
    if (raw[15:12] == 4'h0) return int'(raw[11:0]);
    return 0;
  endfunction

  function automatic logic [23:0] model(input logic [23:0] p);
    logic [23:0] res;
    for (int r = 0; r < 3; r++) begin
      longint t = 0;
      longint q;
      for (int c = 0; c < 3; c++)
        t += longint'(a_coef[r][c]) * longint'(int'(p[(2-c)*8 +: 8]) + a_pre[c]);
      t = t * 2 + (a_lift ? 64'sd131072 : longint'(a_post[r]) * 255);
      q = (t + 4096) >>> 13;
      if (q < 0) q = 0;
      if (q > 255) q = 255;
      res[(2-r)*8 +: 8] = q[7:0];
    end
    return res;
  endfunction

  task automatic shadow_update(input int addr, input logic [31:0] d);
    if (addr < 6) begin
      if (addr % 2 == 0) begin
        s_coef[addr/2][0] = dec(d[31:16]);
        s_coef[addr/2][1] = dec(d[15:0]);
      end else s_coef[addr/2][2] = dec(d[31:16]);
    end else if (addr == 6) begin
      for (int c = 0; c < 3; c++) s_pre[c] = int'($signed(d[c*10 +: 10]));
    end else if (addr >= 7 && addr <= 9) s_post[addr-7] = int'($signed(d[12:0]));
    else if (addr == 10) s_lift = d[0];
  endtask

  task automatic apply_shadow();
    a_coef = s_coef; a_pre = s_pre; a_post = s_post; a_lift = s_lift;
  endtask

  task automatic wr(input int addr, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_addr = 4'(addr); cfg_wr_data = d;
    shadow_update(addr, d);
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic fstart();
    @(negedge clk);
    frame_start = 1'b1;
    apply_shadow();
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic send(input logic [23:0] p);
    @(negedge clk);
    in_valid = 1'b1; in_pix = p;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(model(p));
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic sweep();
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b = 8'(v);
      send({b, ~b, b ^ 8'h5A});
    end
  endtask

  // scoreboard monitor: chooses ready and compares on the transfer it implies
  always @(negedge clk) begin
    if (rst) out_ready = 1'b0;
    else begin
      out_ready = stall_mode ? ($urandom_range(3) != 0) : 1'b1;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R11 unexpected output", {8'h0, out_pix}, 32'h0);
        else begin
          logic [23:0] e;
          e = exp_q.pop_front();
          check(out_pix == e, cur_req, {8'h0, out_pix}, {8'h0, e});
        end
        last_out = out_pix;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R10 actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int r = 0; r < 3; r++) begin
      for (int c = 0; c < 3; c++) s_coef[r][c] = (r == c) ? 4096 : 0;
      s_pre[r] = 0; s_post[r] = 0;
    end
    apply_shadow();
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid in reset", {31'h0, out_valid}, 32'h0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", {31'h0, out_valid}, 32'h0);
    check(in_ready == 1'b1, "R1 in_ready after reset", {31'h0, in_ready}, 32'h1);

    // R10: latency with ready held high
    cur_req = "R10 latency pixel";
    @(negedge clk);
    in_valid = 1'b1; in_pix = 24'h123456;
    exp_q.push_back(model(24'h123456));
    #1 check(in_ready == 1'b1, "R10 accept", {31'h0, in_ready}, 32'h1);
    @(posedge clk); #1 in_valid = 1'b0;
    @(negedge clk); check(out_valid == 1'b0, "R10 edge1", {31'h0, out_valid}, 32'h0);
    @(negedge clk); check(out_valid == 1'b0, "R10 edge2", {31'h0, out_valid}, 32'h0);
    @(negedge clk); check(out_valid == 1'b1, "R10 edge3", {31'h0, out_valid}, 32'h1);
    drain();
    check(last_out == 24'h123456, "R1 R7 latency pixel value", {8'h0, last_out}, 32'h123456);

    // identity sweep with random stalls
    stall_mode = 1'b1;
    cur_req = "R1 R7 R11 identity sweep";
    sweep();
    drain();

    // limited settings written, not yet active
    wr(0, 32'h0DB8_0000); wr(1, 32'h0000_0000);
    wr(2, 32'h0000_0DB8); wr(3, 32'h0000_0000);
    wr(4, 32'h0000_0000); wr(5, 32'h0DB8_0000);
    wr(6, 32'h0); wr(7, 32'h202); wr(8, 32'h202); wr(9, 32'h202);
    cur_req = "R9 shadow not active";
    send(24'h00FF80);
    drain();
    check(last_out == 24'h00FF80, "R9 write without strobe", {8'h0, last_out}, 32'h00FF80);

    fstart();
    cur_req = "R4 R8 R11 limited sweep";
    sweep();
    drain();
    stall_mode = 1'b0;
    send(24'h000000); drain();
    check(last_out == 24'h101010, "R8 black maps to 16", {8'h0, last_out}, 32'h101010);
    send(24'hFFFFFF); drain();
    check(last_out == 24'hEBEBEB, "R8 white maps to 235", {8'h0, last_out}, 32'hEBEBEB);

    // lift mode replaces post-offsets
    wr(7, 32'h0); wr(8, 32'h0); wr(9, 32'h0); wr(10, 32'h1);
    fstart();
    stall_mode = 1'b1;
    cur_req = "R5 lift sweep";
    sweep();
    drain();
    stall_mode = 1'b0;
    send(24'h000000); drain();
    check(last_out == 24'h101010, "R5 R8 lift black", {8'h0, last_out}, 32'h101010);
    send(24'hFFFFFF); drain();
    check(last_out == 24'hEBEBEB, "R5 R8 lift white", {8'h0, last_out}, 32'hEBEBEB);

    // R9: write in the strobe's own cycle waits for the next strobe
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_addr = 4'd10; cfg_wr_data = 32'h0; frame_start = 1'b1;
    apply_shadow();
    shadow_update(10, 32'h0);
    @(negedge clk);
    cfg_wr_en = 1'b0; frame_start = 1'b0;
    cur_req = "R9 same-cycle write";
    send(24'h000000); drain();
    check(last_out == 24'h101010, "R9 same-cycle write deferred", {8'h0, last_out}, 32'h101010);
    fstart();
    send(24'h000000); drain();
    check(last_out == 24'h000000, "R9 write taken at next strobe", {8'h0, last_out}, 32'h000000);

    // cross matrix, invalid code, negative pre-offset, clamps
    wr(0, 32'h7800_7800); wr(1, 32'h8123_0000);
    wr(2, 32'h0800_0000); wr(3, 32'h0400_0000);
    wr(4, 32'h0000_0000); wr(5, 32'h7800_0000);
    wr(6, 32'h3EC0_0000); wr(7, 32'h0); wr(8, 32'h100); wr(9, 32'h0);
    fstart();
    cur_req = "R2 R3 R4 R6 matrix random";
    stall_mode = 1'b1;
    for (int i = 0; i < 64; i++) send(24'($urandom));
    drain();
    stall_mode = 1'b0;
    send(24'hC8640A); drain();
    check(last_out == 24'hFF6900, "R6 R4 clamp high and low", {8'h0, last_out}, 32'hFF6900);
    send(24'h0000FF); drain();
    check(last_out == 24'h0043EB, "R2 R3 invalid code as zero", {8'h0, last_out}, 32'h0043EB);

    check(exp_q.size() == 0, "R11 nothing left pending", exp_q.size(), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule